// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Frame Buffer

This block sits between a pixel source running on one clock and a pixel sink running on a faster, unrelated clock. The storage is a simple dual-port memory split into two equal banks, and the top address bit picks the bank. While the source fills one bank, the sink reads the other. Bank ownership changes only at frame boundaries, so a finished frame stays intact while it is read and every valid incoming pixel lands in memory.

The write side sees a frame-start pulse, a pixel valid and the pixel data. Every frame-start pulse flips the write bank. That one bit is the only state that crosses into the read clock domain, through a two-flop synchroniser. On its own frame-start pulse the read side takes the bank opposite the writer's current bank, which is the last completed frame. It keeps that bank until its next frame start, even if the writer finishes another frame in the meantime. Both reset inputs are active low, asserted asynchronously, and must be released synchronously to their own clock.

Top module: `pp_frame_buf`

## Requirements
- R1: While reset is held and after it is released with no read request, `rd_valid` is 0 and `rd_data` is 0.
- R2: A cycle with `wr_sof` high restarts the write address at 0, and a pixel with `wr_valid` in that same cycle is pixel 0 of the new frame. The write address advances by one only on cycles with `wr_valid` high. Data presented with `wr_valid` low is never stored.
- R3: The write bank is 0 after reset and flips on every `wr_sof` pulse.
- R4: On `rd_sof` the reader selects the bank opposite the writer's current bank, so it reads back the most recently completed frame.
- R5: The read bank is held from one `rd_sof` to the next. A read frame started with no new completed frame repeats the previous frame, and a writer frame boundary in the middle of a read frame does not change the data returned for the rest of that frame.
- R6: A cycle with `rd_sof` high restarts the read address at 0, also in the middle of a frame. The read address advances by one only on cycles with `rd_en` high.
- R7: `rd_data` and `rd_valid` follow `rd_en` by exactly one read-clock cycle. `rd_valid` is 0 after a cycle with `rd_en` low, and `rd_data` then holds its last value.
- R8: The write bank reaches the read domain through a two-flop synchroniser. An `rd_sof` issued three or more read cycles after a `wr_sof` sees the new bank.
- R9: Every pixel written with `wr_valid` in a completed frame is returned in write order, for any pattern of idle cycles between the pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write (source) clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| wr_sof | input | 1 | Start-of-frame pulse from the source |
| wr_valid | input | 1 | Incoming pixel is valid |
| wr_data | input | DATA_W | Incoming pixel |
| rd_clk | input | 1 | Read (display) clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| rd_sof | input | 1 | Start-of-frame pulse from the display |
| rd_en | input | 1 | Request the next pixel |
| rd_data | output | DATA_W | Pixel read from memory, one cycle after the request |
| rd_valid | output | 1 | `rd_data` holds a newly read pixel |

## Verification
A wrong bank bit shows at the ports on the first pixel of the next read frame: the pixels come back from an older frame or from a bank still being filled, so the data pattern of the wrong frame appears at once. A stuck or skipping address counter garbles the order within a frame and shows on the pixel after the fault. A broken synchroniser or bank hold shows as a mid-frame switch of the pattern. Each frame written uses its own base and step, so any mix-up between frames produces a data mismatch that can be told apart.

// File: rtl/pp_fb_pkg.sv
package pp_fb_pkg;
  // number of flops in the bank-bit synchroniser
  localparam int SYNC_STAGES = 2;
  typedef logic bank_sel_t;
endpackage

// File: rtl/pp_bank_sync.sv
module pp_bank_sync #(
  parameter int STAGES = pp_fb_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign chain_d[s] = d_async;
      end else begin : g_next
        assign chain_d[s] = chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

  // R8
  sync_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> q == $past(chain_q[STAGES-2]));
endmodule

// File: rtl/pp_fb_wr.sv
module pp_fb_wr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof,
  input  logic          valid,
  output logic          mem_we,
  output logic [AW:0]   mem_addr,
  output logic          bank_o
);
  logic          bank_q, bank_d, eff_bank;
  logic [AW-1:0] addr_q, addr_d, eff_addr;
  logic          bank_en, addr_en;

  always_comb begin
    eff_bank = sof ? ~bank_q : bank_q;
    eff_addr = sof ? '0 : addr_q;
    bank_d   = eff_bank;
    addr_d   = valid ? eff_addr + 1'b1 : eff_addr;
    bank_en  = sof;
    addr_en  = sof | valid;
    mem_we   = valid;
    mem_addr = {eff_bank, eff_addr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= 1'b0;
    else if (bank_en) bank_q <= bank_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign bank_o = bank_q;

  // R3
  wr_bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> $stable(bank_o));
  // R2
  wr_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !sof) |=> mem_addr[AW-1:0] == AW'($past(mem_addr[AW-1:0]) + 1'b1) || sof);
endmodule

// File: rtl/pp_fb_rd.sv
module pp_fb_rd #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof,
  input  logic          en,
  input  logic          wr_bank_sync,
  output logic          mem_re,
  output logic [AW:0]   mem_addr
);
  logic          bank_q, bank_d, eff_bank;
  logic [AW-1:0] addr_q, addr_d, eff_addr;
  logic          bank_en, addr_en;

  always_comb begin
    eff_bank = sof ? ~wr_bank_sync : bank_q;
    eff_addr = sof ? '0 : addr_q;
    bank_d   = eff_bank;
    addr_d   = en ? eff_addr + 1'b1 : eff_addr;
    bank_en  = sof;
    addr_en  = sof | en;
    mem_re   = en;
    mem_addr = {eff_bank, eff_addr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= 1'b1;
    else if (bank_en) bank_q <= bank_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  // R5
  rd_bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && !$past(sof)) |-> mem_addr[AW] == $past(mem_addr[AW]));
  // R6
  rd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && en) |=> (mem_addr[AW-1:0] == AW'(1) || sof));
endmodule

// File: rtl/pp_fb_ram.sv
module pp_fb_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW:0]   waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW:0]   raddr,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int DEPTH = 2 ** (AW + 1);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rdata <= '0;
    else if (re)  rdata <= mem[raddr];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rvalid <= 1'b0;
    else         rvalid <= re;
  end

  // R7
  rd_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !re |=> (!rvalid && $stable(rdata)));
endmodule

// File: rtl/pp_frame_buf.sv
module pp_frame_buf #(
  parameter int DATA_W = 8,
  parameter int PIX_AW = 4
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_sof,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_sof,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic            w_we, w_bank, r_re, bank_in_rd;
  logic [PIX_AW:0] w_addr, r_addr;

  pp_fb_wr #(.AW(PIX_AW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .sof(wr_sof), .valid(wr_valid),
    .mem_we(w_we), .mem_addr(w_addr), .bank_o(w_bank)
  );

  pp_bank_sync u_sync (
    .clk(rd_clk), .rst_n(rd_rst_n), .d_async(w_bank), .q(bank_in_rd)
  );

  pp_fb_rd #(.AW(PIX_AW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .sof(rd_sof), .en(rd_en),
    .wr_bank_sync(bank_in_rd), .mem_re(r_re), .mem_addr(r_addr)
  );

  pp_fb_ram #(.DW(DATA_W), .AW(PIX_AW)) u_ram (
    .wclk(wr_clk), .we(w_we), .waddr(w_addr), .wdata(wr_data),
    .rclk(rd_clk), .rrst_n(rd_rst_n), .re(r_re), .raddr(r_addr),
    .rdata(rd_data), .rvalid(rd_valid)
  );

  // R7
  rd_valid_follow_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_en |=> rd_valid);
endmodule

// File: tb/pp_frame_buf_test.sv
module pp_frame_buf_test;
  localparam int WR_PERIOD = 58;
  localparam int RD_PERIOD = 40;
  localparam int DW  = 8;
  localparam int AW  = 4;
  localparam int PIX = 2 ** AW;

  typedef struct packed {
    logic [7:0] base;
    logic [7:0] step;
    logic       gap;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{base: 8'h10, step: 8'h01, gap: 1'b0},
    '{base: 8'h80, step: 8'h03, gap: 1'b1},
    '{base: 8'hF0, step: 8'hFF, gap: 1'b0},
    '{base: 8'h25, step: 8'h07, gap: 1'b1}
  };

  logic          wr_clk = 0, rd_clk = 0;
  logic          wr_rst_n = 0, rd_rst_n = 0;
  logic          wr_sof = 0, wr_valid = 0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_sof = 0, rd_en = 0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int total = 0;
  int bad   = 0;

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  pp_frame_buf #(.DATA_W(DW), .PIX_AW(AW)) uut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_sof(wr_sof),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_sof(rd_sof),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pix(input logic [7:0] b, input logic [7:0] s, input int i);
    return 8'(b + s * i);
  endfunction

  task automatic wr_frame(input vec_t v);
    for (int i = 0; i < PIX; i++) begin
      @(negedge wr_clk);
      wr_sof = (i == 0); wr_valid = 1'b1; wr_data = pix(v.base, v.step, i);
      if (v.gap) begin
        @(negedge wr_clk);
        wr_sof = 1'b0; wr_valid = 1'b0; wr_data = 8'hEE;
      end
    end
    @(negedge wr_clk);
    wr_sof = 1'b0; wr_valid = 1'b0;
  endtask

  task automatic wr_boundary();
    @(negedge wr_clk); wr_sof = 1'b1; wr_valid = 1'b0;
    @(negedge wr_clk); wr_sof = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge rd_clk);
  endtask

  task automatic rd_frame(input vec_t v, input string req);
    @(negedge rd_clk); rd_sof = 1'b1; rd_en = 1'b1;
    for (int i = 0; i < PIX; i++) begin
      @(negedge rd_clk);
      check(rd_valid && rd_data == pix(v.base, v.step, i), req,
            rd_data, pix(v.base, v.step, i));
      rd_sof = 1'b0; rd_en = (i < PIX - 1);
    end
    @(negedge rd_clk);
    check(!rd_valid, "R7 valid drops", rd_valid, 0);
  endtask

  initial begin
    #(200000 * RD_PERIOD);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    // R1 reset state
    #(3 * WR_PERIOD);
    check(rd_valid == 1'b0, "R1 rd_valid in reset", rd_valid, 0);
    check(rd_data == '0, "R1 rd_data in reset", rd_data, 0);
    @(negedge wr_clk); wr_rst_n = 1'b1;
    @(negedge rd_clk); rd_rst_n = 1'b1;
    repeat (3) @(negedge rd_clk);
    check(rd_valid == 1'b0 && rd_data == '0, "R1 after release", rd_data, 0);

    // vector table: each frame read back once its successor starts (R2 R3 R4 R8 R9)
    for (int k = 0; k < 4; k++) begin
      wr_frame(VEC[k]);
      settle();
      if (k > 0) rd_frame(VEC[k-1], "R9 frame data");
    end
    wr_boundary();
    settle();
    rd_frame(VEC[3], "R4 latest frame");
    // R5: no new frame completed, same frame repeats
    rd_frame(VEC[3], "R5 repeat frame");

    // R5: writer boundary in mid read frame; R7 pause holds data
    @(negedge rd_clk); rd_sof = 1'b1; rd_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge rd_clk);
      check(rd_data == pix(VEC[3].base, VEC[3].step, i), "R5 before swap",
            rd_data, pix(VEC[3].base, VEC[3].step, i));
      rd_sof = 1'b0; rd_en = (i < 5);
    end
    held = rd_data;
    wr_boundary();
    settle();
    check(!rd_valid && rd_data == held, "R7 hold on pause", rd_data, held);
    rd_en = 1'b1;
    for (int i = 6; i < PIX; i++) begin
      @(negedge rd_clk);
      check(rd_valid && rd_data == pix(VEC[3].base, VEC[3].step, i), "R5 after swap",
            rd_data, pix(VEC[3].base, VEC[3].step, i));
      rd_en = (i < PIX - 1);
    end

    // R4: next rd_sof picks the other bank (still holds frame 2); R6 mid-frame restart
    @(negedge rd_clk); rd_sof = 1'b1; rd_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge rd_clk);
      check(rd_data == pix(VEC[2].base, VEC[2].step, i), "R4 new bank",
            rd_data, pix(VEC[2].base, VEC[2].step, i));
      rd_sof = 1'b0;
    end
    rd_sof = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge rd_clk);
      check(rd_valid && rd_data == pix(VEC[2].base, VEC[2].step, i), "R6 restart",
            rd_data, pix(VEC[2].base, VEC[2].step, i));
      rd_sof = 1'b0; rd_en = (i < 2);
    end
    @(negedge rd_clk);
    check(!rd_valid, "R7 valid drops", rd_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule